// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

The controller gathers interrupt events from sixteen numbered sources and two exception requests. It keeps a pending bit for each one and, on every clock, picks the single request the CPU should service next. The result is a registered request strobe together with the winner's number and its 16-bit vector address. Sources 0 to 14 are maskable. Each of them can also be handed to a peripheral transaction server, and a source handed over this way is served from a second vector table. Source 15 is a non-maskable interrupt taken on a rising edge. The two exceptions, an unimplemented opcode and a software trap, are always served first.

The arbitration has four tiers. The exceptions come first, with the unimplemented opcode ahead of the trap. The non-maskable interrupt comes next. Then come enabled sources assigned to the transaction server, and last the ordinary enabled sources. Within each of the last two tiers the higher source number wins. The serial port raises two flags, transmit and receive. Depending on the mask these flags land either on one combined source or on two dedicated sources. The CPU acknowledges the request it services by number, and that clears the matching pending bit.

Top module: `irq_vector_arbiter`

## Requirements
- R1: An event on `evt_i[n]` (n from 0 to 14) sets `pend_o[n]` at the clock edge that samples it, whatever the mask, the server assignment or the global enable. A pending bit stays set until it is acknowledged or cleared.
- R2: `pend_o[15]` is set only on a rising edge of the level on `evt_i[15]`. A level that stays high does not set the bit again after it has been acknowledged.
- R3: A pending unimplemented-opcode request wins over everything and gives number 16 and vector 2012h. A pending software trap wins over everything except that request and gives number 17 and vector 2010h. The global enable has no effect on either.
- R4: When no exception is pending, a pending source 15 wins and gives vector 203Eh with `pts_o` low. The mask and the global enable have no effect on it.
- R5: A source n (0 to 14) that is pending, unmasked (`mask_i[n]`=1) and assigned to the server (`pts_sel_i[n]`=1) wins over every ordinary source. Among several such sources the highest number wins. The request carries `pts_o`=1 and vector 2040h+2n.
- R6: Among pending, unmasked sources that are not assigned to the server, the highest number wins, with `pts_o`=0. The vector is 2000h+2n for n from 0 to 7 and 2030h+2(n-8) for n from 8 to 14.
- R7: While `glb_en_i` is low, no source from 0 to 14 produces a request, and the pending bits are kept.
- R8: When `mask_i[6]`=0, a pulse on `ser_tx_i` sets pending bit 8 and a pulse on `ser_rx_i` sets pending bit 9. Neither sets bit 6.
- R9: When `mask_i[6]`=1, a pulse on either serial flag sets pending bit 6 only.
- R10: `ack_i` with `ack_num_i`=k clears pending bit k (0 to 15), the unimplemented-opcode request (k=16) or the trap request (k=17). An event for the same source in the same cycle wins, and the bit stays set.
- R11: A 1 on bit n of `pend_clr_i` clears pending bit n for one cycle's write.
- R12: Outputs are registered. They reflect the pending state and controls as they stood before the previous clock edge. After reset `req_o`, `num_o`, `vec_o`, `pts_o` and `pend_o` are all zero. With no request, number, vector and `pts_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Event pulses for sources 0..14; level of the non-maskable line on bit 15 |
| ser_tx_i | input | 1 | Serial transmit flag pulse |
| ser_rx_i | input | 1 | Serial receive flag pulse |
| unimpl_i | input | 1 | Unimplemented-opcode request pulse |
| trap_i | input | 1 | Software-trap request pulse |
| mask_i | input | 15 | Enable per maskable source, 1 = enabled |
| pts_sel_i | input | 15 | Per-source assignment to the transaction server |
| glb_en_i | input | 1 | Global enable for maskable sources |
| ack_i | input | 1 | Acknowledge strobe |
| ack_num_i | input | 5 | Number being acknowledged (0..15, 16 opcode, 17 trap) |
| pend_clr_i | input | 16 | Write-one-to-clear pending bits |
| req_o | output | 1 | Request to the CPU |
| num_o | output | 5 | Winning number |
| vec_o | output | 16 | Winning vector address |
| pts_o | output | 1 | Winner is served through the transaction server table |
| pend_o | output | 16 | Pending bits of sources 0..15 |

## Verification
Some properties are checked on every cycle. The vector sent with a request must match its number and table: the exception vectors, 203Eh for the non-maskable interrupt, and the server and low ordinary tables. A request from a maskable source must never follow a cycle in which the global enable was low. Pending bits must never drop unless an acknowledge or a clear was given. An acknowledge with no competing event must clear its bit. Some behaviour can only be shown by the bench scenarios. These are the tier ordering between concurrent requests, the highest-number choice inside a tier, edge-only capture of the non-maskable line while it is held high, set-over-acknowledge in the same cycle, and the way the serial flags are routed under each mask setting.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam logic [15:0] VEC_LO_BASE  = 16'h2000;
  localparam logic [15:0] VEC_HI_BASE  = 16'h2030;
  localparam logic [15:0] VEC_PTS_BASE = 16'h2040;
  localparam logic [15:0] VEC_UNIMPL   = 16'h2012;
  localparam logic [15:0] VEC_TRAP     = 16'h2010;

  localparam int SRC_SER_COMB = 6;
  localparam int SRC_SER_TX   = 8;
  localparam int SRC_SER_RX   = 9;

  typedef enum logic [2:0] {
    WIN_NONE, WIN_UNIMPL, WIN_TRAP, WIN_NMI, WIN_PTS, WIN_STD
  } win_kind_e;

  function automatic logic [15:0] std_vec(input logic [15:0] n);
    if (n < 16'd8) return VEC_LO_BASE + (n << 1);
    return VEC_HI_BASE + ((n - 16'd8) << 1);
  endfunction

  function automatic logic [15:0] pts_vec(input logic [15:0] n);
    return VEC_PTS_BASE + (n << 1);
  endfunction
endpackage

// File: rtl/ivc_pend_bank.sv
module ivc_pend_bank
  import ivc_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NUMW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            ser_tx_i,
  input  logic            ser_rx_i,
  input  logic            ser_comb_en_i,
  input  logic            unimpl_i,
  input  logic            trap_i,
  input  logic            ack_i,
  input  logic [NUMW-1:0] ack_num_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o,
  output logic            unimpl_pend_o,
  output logic            trap_pend_o
);
  localparam int NMI_IDX = NSRC - 1;

  logic            nmi_q;
  logic [NSRC-1:0] set_v;
  logic            ack_unimpl, ack_trap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nmi_q <= 1'b0;
    else         nmi_q <= evt_i[NMI_IDX];
  end

  // serial flags are routed at capture time by the combined-source enable
  always_comb begin
    set_v          = evt_i;
    set_v[NMI_IDX] = evt_i[NMI_IDX] & ~nmi_q;
    if (ser_comb_en_i) begin
      set_v[SRC_SER_COMB] = evt_i[SRC_SER_COMB] | ser_tx_i | ser_rx_i;
    end else begin
      set_v[SRC_SER_TX] = evt_i[SRC_SER_TX] | ser_tx_i;
      set_v[SRC_SER_RX] = evt_i[SRC_SER_RX] | ser_rx_i;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic ack_hit;
    assign ack_hit = ack_i && (ack_num_i == NUMW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[i] <= 1'b0;
      else         pend_o[i] <= set_v[i] | (pend_o[i] & ~ack_hit & ~clr_i[i]);
    end
  end

  assign ack_unimpl = ack_i && (ack_num_i == NUMW'(NSRC));
  assign ack_trap   = ack_i && (ack_num_i == NUMW'(NSRC + 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unimpl_pend_o <= 1'b0;
      trap_pend_o   <= 1'b0;
    end else begin
      unimpl_pend_o <= unimpl_i | (unimpl_pend_o & ~ack_unimpl);
      trap_pend_o   <= trap_i   | (trap_pend_o   & ~ack_trap);
    end
  end
endmodule

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick #(
  parameter int N  = 15,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import ivc_pkg::*;
#(
  parameter  int NSRC = 16,
  localparam int NUMW = $clog2(NSRC) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            ser_tx_i,
  input  logic            ser_rx_i,
  input  logic            unimpl_i,
  input  logic            trap_i,
  input  logic [NSRC-2:0] mask_i,
  input  logic [NSRC-2:0] pts_sel_i,
  input  logic            glb_en_i,
  input  logic            ack_i,
  input  logic [NUMW-1:0] ack_num_i,
  input  logic [NSRC-1:0] pend_clr_i,
  output logic            req_o,
  output logic [NUMW-1:0] num_o,
  output logic [15:0]     vec_o,
  output logic            pts_o,
  output logic [NSRC-1:0] pend_o
);
  localparam int NMSK = NSRC - 1;
  localparam int IW   = $clog2(NSRC);

  logic            unimpl_pend, trap_pend;
  logic [NMSK-1:0] elig, pts_req, std_req;
  logic            pts_any, std_any;
  logic [IW-1:0]   pts_idx, std_idx;
  win_kind_e       kind;
  logic [NUMW-1:0] num_d;
  logic [15:0]     vec_d;

  ivc_pend_bank #(.NSRC(NSRC), .NUMW(NUMW)) u_pend (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .evt_i         (evt_i),
    .ser_tx_i      (ser_tx_i),
    .ser_rx_i      (ser_rx_i),
    .ser_comb_en_i (mask_i[SRC_SER_COMB]),
    .unimpl_i      (unimpl_i),
    .trap_i        (trap_i),
    .ack_i         (ack_i),
    .ack_num_i     (ack_num_i),
    .clr_i         (pend_clr_i),
    .pend_o        (pend_o),
    .unimpl_pend_o (unimpl_pend),
    .trap_pend_o   (trap_pend)
  );

  assign elig    = pend_o[NMSK-1:0] & mask_i & {NMSK{glb_en_i}};
  assign pts_req = elig & pts_sel_i;
  assign std_req = elig & ~pts_sel_i;

  ivc_prio_pick #(.N(NMSK), .IW(IW)) u_pick_pts (
    .req_i (pts_req), .any_o (pts_any), .idx_o (pts_idx)
  );

  ivc_prio_pick #(.N(NMSK), .IW(IW)) u_pick_std (
    .req_i (std_req), .any_o (std_any), .idx_o (std_idx)
  );

  always_comb begin
    if (unimpl_pend)         kind = WIN_UNIMPL;
    else if (trap_pend)      kind = WIN_TRAP;
    else if (pend_o[NSRC-1]) kind = WIN_NMI;
    else if (pts_any)        kind = WIN_PTS;
    else if (std_any)        kind = WIN_STD;
    else                     kind = WIN_NONE;
  end

  always_comb begin
    num_d = '0;
    vec_d = '0;
    unique case (kind)
      WIN_UNIMPL: begin num_d = NUMW'(NSRC);     vec_d = VEC_UNIMPL; end
      WIN_TRAP:   begin num_d = NUMW'(NSRC + 1); vec_d = VEC_TRAP;   end
      WIN_NMI:    begin num_d = NUMW'(NSRC - 1); vec_d = std_vec(16'(NSRC - 1)); end
      WIN_PTS:    begin num_d = NUMW'(pts_idx);  vec_d = pts_vec(16'(pts_idx)); end
      WIN_STD:    begin num_d = NUMW'(std_idx);  vec_d = std_vec(16'(std_idx)); end
      default:    begin num_d = '0;              vec_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      num_o <= '0;
      vec_o <= '0;
      pts_o <= 1'b0;
    end else begin
      req_o <= (kind != WIN_NONE);
      num_o <= num_d;
      vec_o <= vec_d;
      pts_o <= (kind == WIN_PTS);
    end
  end
endmodule

// File: rtl/irq_vector_arbiter_chk.sv
module irq_vector_arbiter_chk #(
  parameter  int NSRC = 16,
  localparam int NUMW = $clog2(NSRC) + 1,
  localparam int IW   = $clog2(NSRC)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] evt_i,
  input logic            ser_tx_i,
  input logic            ser_rx_i,
  input logic            glb_en_i,
  input logic            ack_i,
  input logic [NUMW-1:0] ack_num_i,
  input logic [NSRC-1:0] pend_clr_i,
  input logic            req_o,
  input logic [NUMW-1:0] num_o,
  input logic [15:0]     vec_o,
  input logic            pts_o,
  input logic [NSRC-1:0] pend_o
);
  // R3
  a_r3_unimpl_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && num_o == NUMW'(NSRC)) |-> (vec_o == 16'h2012 && !pts_o));
  a_r3_trap_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && num_o == NUMW'(NSRC + 1)) |-> (vec_o == 16'h2010 && !pts_o));
  // R4
  a_r4_nmi_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && num_o == NUMW'(NSRC - 1)) |-> (vec_o == 16'h203E && !pts_o));
  // R5
  a_r5_pts_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && pts_o) |-> (num_o < NUMW'(NSRC - 1) && vec_o == 16'h2040 + (16'(num_o) << 1)));
  // R6
  a_r6_low_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !pts_o && num_o < NUMW'(8)) |-> (vec_o == 16'h2000 + (16'(num_o) << 1)));
  // R7
  a_r7_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !$past(glb_en_i)) |-> (num_o >= NUMW'(NSRC - 1)));
  // R1
  a_r1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && pend_clr_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
  // R10
  a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_num_i < NUMW'(NSRC) && evt_i == '0 && !ser_tx_i && !ser_rx_i)
    |=> !pend_o[$past(ack_num_i[IW-1:0])]);
  // R12
  a_r12_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (num_o == '0 && vec_o == '0 && !pts_o));
endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/irq_vector_arbiter_test.sv
module irq_vector_arbiter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] evt_i = '0;
  logic        ser_tx_i = 1'b0, ser_rx_i = 1'b0;
  logic        unimpl_i = 1'b0, trap_i = 1'b0;
  logic [14:0] mask_i = '0, pts_sel_i = '0;
  logic        glb_en_i = 1'b1;
  logic        ack_i = 1'b0;
  logic [4:0]  ack_num_i = '0;
  logic [15:0] pend_clr_i = '0;
  logic        req_o, pts_o;
  logic [4:0]  num_o;
  logic [15:0] vec_o, pend_o;

  int checks = 0;
  int errors = 0;
  logic nmi_lvl = 1'b0;

  typedef struct {
    logic        req;
    logic [4:0]  num;
    logic [15:0] vec;
    logic        pts;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  event samp_ev;

  always #2.5 clk_i = ~clk_i;

  irq_vector_arbiter uut (.*);

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic expect_out(input logic r, input logic [4:0] n, input logic [15:0] v,
                            input logic p, input string tag);
    exp_t e;
    e.req = r; e.num = n; e.vec = v; e.pts = p; e.tag = tag;
    exp_q.push_back(e);
    -> samp_ev;
    #0;
  endtask

  task automatic chk_pend(input logic [15:0] exp, input string tag);
    checks++;
    if (pend_o !== exp) begin
      errors++;
      $display("FAIL %s pend: act=%h exp=%h", tag, pend_o, exp);
    end
  endtask

  initial forever begin
    @(samp_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if ({req_o, num_o, vec_o, pts_o} !== {e.req, e.num, e.vec, e.pts}) begin
        errors++;
        $display("FAIL %s: act req=%b num=%0d vec=%h pts=%b exp req=%b num=%0d vec=%h pts=%b",
                 e.tag, req_o, num_o, vec_o, pts_o, e.req, e.num, e.vec, e.pts);
      end
    end
  end

  // one-cycle pulse on a source; ends with pend updated, output one tick later
  task automatic pulse(input logic [15:0] bits);
    evt_i = bits | {nmi_lvl, 15'd0};
    tick();
    evt_i = {nmi_lvl, 15'd0};
  endtask

  task automatic ack(input logic [4:0] n);
    ack_i = 1'b1; ack_num_i = n;
    tick();
    ack_i = 1'b0;
  endtask

  task automatic set_nmi(input logic v);
    nmi_lvl = v;
    evt_i[15] = v;
  endtask

  task automatic run_all;
    tick(2);
    expect_out(0, 0, 16'h0, 0, "R12 reset outputs");
    chk_pend(16'h0, "R12 reset pend");
    rst_ni = 1'b1;
    tick(2);

    pulse(16'h0008);
    chk_pend(16'h0008, "R1 set while masked");
    tick();
    expect_out(0, 0, 16'h0, 0, "R1 masked no request");

    mask_i[3] = 1'b1; tick();
    expect_out(1, 3, 16'h2006, 0, "R6 single source");
    mask_i[5] = 1'b1; pulse(16'h0020); tick();
    expect_out(1, 5, 16'h200A, 0, "R6 higher number wins");
    mask_i[12] = 1'b1; pulse(16'h1000); tick();
    expect_out(1, 12, 16'h2038, 0, "R6 upper table");

    pts_sel_i[3] = 1'b1; tick();
    expect_out(1, 3, 16'h2046, 1, "R5 server beats ordinary");
    pts_sel_i[5] = 1'b1; tick();
    expect_out(1, 5, 16'h204A, 1, "R5 higher server source");

    glb_en_i = 1'b0; tick();
    expect_out(0, 0, 16'h0, 0, "R7 global disable");
    chk_pend(16'h1028, "R7 pending kept");
    glb_en_i = 1'b1;

    set_nmi(1'b1); tick();
    chk_pend(16'h9028, "R2 rising edge latched");
    tick();
    expect_out(1, 15, 16'h203E, 0, "R4 nmi over server");
    ack(5'd15); tick();
    expect_out(1, 5, 16'h204A, 1, "R10 nmi acknowledged");
    chk_pend(16'h1028, "R2 held level no reset");
    tick(3);
    chk_pend(16'h1028, "R2 held level still clear");
    set_nmi(1'b0); tick();
    set_nmi(1'b1); tick();
    chk_pend(16'h9028, "R2 second edge");
    ack(5'd15); set_nmi(1'b0); tick();

    glb_en_i = 1'b0;
    trap_i = 1'b1; tick(); trap_i = 1'b0; tick();
    expect_out(1, 17, 16'h2010, 0, "R3 trap while disabled");
    unimpl_i = 1'b1; tick(); unimpl_i = 1'b0; tick();
    expect_out(1, 16, 16'h2012, 0, "R3 unimplemented first");
    ack(5'd16); tick();
    expect_out(1, 17, 16'h2010, 0, "R10 unimpl acknowledged");
    ack(5'd17); tick();
    expect_out(0, 0, 16'h0, 0, "R10 trap acknowledged");
    glb_en_i = 1'b1; tick();
    expect_out(1, 5, 16'h204A, 1, "R5 back to server source");

    ack_i = 1'b1; ack_num_i = 5'd5; evt_i = 16'h0020;
    tick();
    ack_i = 1'b0; evt_i = '0;
    chk_pend(16'h1028, "R10 event beats ack");
    tick();
    expect_out(1, 5, 16'h204A, 1, "R10 source still served");
    ack(5'd5);
    chk_pend(16'h1008, "R10 ack clears");
    tick();
    expect_out(1, 3, 16'h2046, 1, "R10 next server source");

    pend_clr_i = 16'h1008; tick(); pend_clr_i = '0;
    chk_pend(16'h0000, "R11 clear write");
    tick();
    expect_out(0, 0, 16'h0, 0, "R11 nothing pending");

    mask_i = '0; pts_sel_i = '0;
    ser_tx_i = 1'b1; tick(); ser_tx_i = 1'b0;
    chk_pend(16'h0100, "R8 tx to source 8");
    ser_rx_i = 1'b1; tick(); ser_rx_i = 1'b0;
    chk_pend(16'h0300, "R8 rx to source 9");
    pend_clr_i = 16'hFFFF; tick(); pend_clr_i = '0;
    mask_i[6] = 1'b1;
    ser_tx_i = 1'b1; tick(); ser_tx_i = 1'b0;
    chk_pend(16'h0040, "R9 tx to combined");
    pend_clr_i = 16'h0040; tick(); pend_clr_i = '0;
    ser_rx_i = 1'b1; tick(); ser_rx_i = 1'b0;
    chk_pend(16'h0040, "R9 rx to combined");
    tick();
    expect_out(1, 6, 16'h200C, 0, "R6 combined serial source");
    mask_i[8] = 1'b1; mask_i[9] = 1'b1;
    pulse(16'h0300); tick();
    expect_out(1, 9, 16'h2032, 0, "R6 source 9 vector");

    pend_clr_i = 16'hFFFF; tick(); pend_clr_i = '0;
    mask_i = 15'h0001; pulse(16'h0001); tick();
    expect_out(1, 0, 16'h2000, 0, "R6 lowest source");
    mask_i[14] = 1'b1; pts_sel_i[14] = 1'b1; pulse(16'h4000); tick();
    expect_out(1, 14, 16'h205C, 1, "R5 top server vector");
    tick();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: act=timeout exp=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule